// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources and tells a CPU core which one to service next and where its service routine starts. The sources are two external request pins (active low), three timer overflow events and a serial-port request. Software sets which sources may interrupt in an enable register, and which of them are urgent in a priority register. Each external pin can be configured to request on a low level or on a falling edge.

The CPU watches `irq_req` and `irq_vec`. When it takes the request it pulses `irq_ack`. The controller then records the level of the accepted request on a small in-service stack. It also clears the latched flag of that source, where hardware owns the clearing. When the routine finishes, the CPU pulses `irq_ret` and the stack drops one level. A low-level routine can be interrupted once by a high-level one. A high-level routine cannot be interrupted at all.

Top module: `vic2_ctrl`

## Requirements
- R1: While enable-register bit 7 (global enable) is 0, `irq_req` stays 0, whatever the per-source enable bits and pending flags hold.
- R2: Source index k (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2) can only be requested while enable bit k is 1. Clearing that bit withdraws a pending request.
- R3: Among eligible requests of the same level, the lowest index wins, and `irq_vec` = 3 + 8*k (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B). `irq_vec` is 0 while `irq_req` is 0.
- R4: While a low-level routine is in service, only a request whose priority bit is 1 (high level) is presented. A request of the same low level waits.
- R5: While a high-level routine is on top of the stack, no request is presented.
- R6: With type bit 1, a falling edge on an external pin (one synchronized sample high, then one low) sets its flag (`flag_q` bit 0 for ext0, bit 2 for ext1). The flag stays set after the pin returns high.
- R7: With type bit 0, an external source requests while its synchronized pin is low and stops when the pin is high. No flag is latched.
- R8: Acknowledging an edge-mode external source or a timer 0/1 source clears that flag (`flag_q` bit 1 timer0, bit 3 timer1) on the acknowledging clock edge.
- R9: The serial and timer2 requests are level inputs that acknowledge does not clear. They request again after the return if still high.
- R10: `irq_ack` with a request pushes its level, and `irq_ret` pops one level. `svc_depth` reports the stack occupancy (0..2).
- R11: After reset all registers and flags read 0 and no request is presented. Enable bit 6 and priority bits 7..6 always read 0.
- R12: `irq_ack` while no request is presented, or `irq_ret` with an empty stack, leaves `svc_depth` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write `cfg_wdata` into the enable register |
| cfg_wr_pri | input | 1 | Write `cfg_wdata` into the priority register |
| cfg_wdata | input | 8 | Register write data |
| en_rd | output | 8 | Enable register read value |
| pri_rd | output | 8 | Priority register read value |
| ext_n | input | 2 | External request pins, active low (bit 0 ext0, bit 1 ext1) |
| ext_type | input | 2 | Per-pin trigger type: 1 falling edge, 0 low level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_flag | input | 1 | Serial request (receive or transmit flag) |
| tm2_flag | input | 1 | Timer 2 request (overflow or external flag) |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | CPU has finished the current routine |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 8 | Start address of the presented request's routine |
| irq_hi | output | 1 | Presented request is high level |
| flag_q | output | 4 | Latched flags {timer1, ext1, timer0, ext0} |
| svc_depth | output | 2 | In-service stack occupancy |

## Verification
The bench builds the controller with its defaults: a two-stage pin synchronizer, 8-bit vectors with base 3 and stride 8, and a two-entry in-service stack. The stack depth lets a low-level routine be preempted and then filled to the top, so the bench can check the full-stack blocking of R5 and the return sequence that unwinds it. The synchronizer depth sets the delay before an edge flag or level request shows. The bench waits long enough for both, so the sticky-flag and level-follow cases of R6 and R7 are observed at the ports.

// File: rtl/vic2_pkg.sv
package vic2_pkg;
   localparam int NSRC      = 6;
   localparam int SRC_IDX_W = 3;
   localparam int GLB_BIT   = 7;
   // source indices, also their bit positions in both registers
   localparam int SRC_X0  = 0;
   localparam int SRC_T0  = 1;
   localparam int SRC_X1  = 2;
   localparam int SRC_T1  = 3;
   localparam int SRC_SER = 4;
   localparam int SRC_T2  = 5;
   localparam logic [7:0] EN_MASK  = 8'hBF;
   localparam logic [7:0] PRI_MASK = 8'h3F;
endpackage

// File: rtl/vic2_ext_chan.sv
module vic2_ext_chan #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req,
   output logic flag
);
   logic cur;
   logic prev_q;
   logic fall;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= pin_n;
         end
         assign cur = s_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], pin_n};
         end
         assign cur = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign fall = prev_q & ~cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         flag   <= 1'b0;
      end else begin
         prev_q <= cur;
         if (edge_mode && fall) flag <= 1'b1;
         else if (clr)          flag <= 1'b0;
      end
   end

   assign req = edge_mode ? flag : ~cur;

   // R6: a detected fall in edge mode leaves the flag set
   p_fall_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && prev_q && !cur) |=> flag);
   // R8: acknowledge without a fresh edge drops the flag
   p_ack_drops_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(edge_mode && prev_q && !cur)) |=> !flag);
endmodule

// File: rtl/vic2_pick.sv
module vic2_pick
   import vic2_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic [NSRC-1:0]      pend,
   input  logic [NSRC-1:0]      en_src,
   input  logic                 glb,
   input  logic [NSRC-1:0]      pri_src,
   input  logic                 allow_hi,
   input  logic                 allow_lo,
   output logic                 valid,
   output logic                 win_hi,
   output logic [SRC_IDX_W-1:0] idx,
   output logic [NSRC-1:0]      grant,
   output logic [VEC_W-1:0]     vec
);
   logic [NSRC-1:0] elig, hi_set, lo_set, sel;

   always_comb begin
      elig   = pend & en_src & {NSRC{glb}};
      hi_set = elig & pri_src & {NSRC{allow_hi}};
      lo_set = elig & ~pri_src & {NSRC{allow_lo}};
      win_hi = |hi_set;
      sel    = win_hi ? hi_set : lo_set;
      valid  = |sel;
      idx    = '0;
      grant  = '0;
      vec    = '0;
      // scan from the weakest so the lowest index wins last
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (sel[i]) begin
            idx      = SRC_IDX_W'(i);
            grant    = '0;
            grant[i] = 1'b1;
            vec      = VEC_W'(VEC_BASE + i * VEC_STRIDE);
         end
      end
   end
endmodule

// File: rtl/vic2_svc_stack.sv
module vic2_svc_stack #(
   parameter int DEPTH = 2,
   localparam int DW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          push_hi,
   input  logic          pop,
   output logic [DW-1:0] depth,
   output logic          top_hi,
   output logic          allow_hi,
   output logic          allow_lo
);
   logic [DEPTH-1:0] lvl_q;
   logic             full, empty;

   assign full  = (depth == DW'(DEPTH));
   assign empty = (depth == '0);

   always_comb begin
      top_hi = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (depth == DW'(i + 1)) top_hi = lvl_q[i];
   end

   assign allow_hi = empty || (!top_hi && !full);
   assign allow_lo = empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth <= '0;
         lvl_q <= '0;
      end else if (push && !pop && !full) begin
         for (int i = 0; i < DEPTH; i++)
            if (depth == DW'(i)) lvl_q[i] <= push_hi;
         depth <= depth + 1'b1;
      end else if (pop && !push && !empty) begin
         depth <= depth - 1'b1;
      end else if (push && pop && !empty) begin
         for (int i = 0; i < DEPTH; i++)
            if (depth == DW'(i + 1)) lvl_q[i] <= push_hi;
      end
   end

   // R10: occupancy never passes the stack size
   p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DW'(DEPTH));
   // R10: a lone return removes exactly one level
   p_pop_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (depth == $past(depth) - 1'b1));
   // R5: nothing is accepted over a high-level routine
   p_no_push_over_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && top_hi) |-> !push);
endmodule

// File: rtl/vic2_ctrl.sv
module vic2_ctrl
   import vic2_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STRIDE  = 8,
   parameter int SVC_DEPTH   = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_wr_en,
   input  logic                           cfg_wr_pri,
   input  logic [7:0]                     cfg_wdata,
   output logic [7:0]                     en_rd,
   output logic [7:0]                     pri_rd,
   input  logic [1:0]                     ext_n,
   input  logic [1:0]                     ext_type,
   input  logic                           tmr0_ovf,
   input  logic                           tmr1_ovf,
   input  logic                           ser_flag,
   input  logic                           tm2_flag,
   input  logic                           irq_ack,
   input  logic                           irq_ret,
   output logic                           irq_req,
   output logic [VEC_W-1:0]               irq_vec,
   output logic                           irq_hi,
   output logic [3:0]                     flag_q,
   output logic [$clog2(SVC_DEPTH+1)-1:0] svc_depth
);
   localparam int DW = $clog2(SVC_DEPTH + 1);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (VEC_BASE + (NSRC - 1) * VEC_STRIDE >= (1 << VEC_W)) begin : g_bad_vec
         $error("vector table does not fit VEC_W");
      end
      if (SVC_DEPTH < 2) begin : g_bad_depth
         $error("SVC_DEPTH must allow one preemption");
      end
   endgenerate

   logic [7:0]           en_q, pri_q;
   logic [1:0]           x_req, x_flag, tf_q;
   logic [NSRC-1:0]      pend, grant;
   logic [SRC_IDX_W-1:0] win_idx;
   logic                 win_valid, win_hi, take;
   logic                 top_hi, allow_hi, allow_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
      end else begin
         if (cfg_wr_en)  en_q  <= cfg_wdata & EN_MASK;
         if (cfg_wr_pri) pri_q <= cfg_wdata & PRI_MASK;
      end
   end
   assign en_rd  = en_q;
   assign pri_rd = pri_q;

   assign take = irq_ack & win_valid;

   // external channels sit at even indices, timers at the odd ones
   generate
      for (genvar c = 0; c < 2; c++) begin : g_pair
         vic2_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[c]),
            .edge_mode (ext_type[c]),
            .clr       (take && (win_idx == SRC_IDX_W'(2 * c))),
            .req       (x_req[c]),
            .flag      (x_flag[c])
         );

         logic ovf;
         assign ovf = (c == 0) ? tmr0_ovf : tmr1_ovf;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        tf_q[c] <= 1'b0;
            else if (ovf)                                      tf_q[c] <= 1'b1;
            else if (take && win_idx == SRC_IDX_W'(2 * c + 1)) tf_q[c] <= 1'b0;
         end
      end
   endgenerate

   assign pend   = {tm2_flag, ser_flag, tf_q[1], x_req[1], tf_q[0], x_req[0]};
   assign flag_q = {tf_q[1], x_flag[1], tf_q[0], x_flag[0]};

   vic2_pick #(
      .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_pick (
      .pend     (pend),
      .en_src   (en_q[NSRC-1:0]),
      .glb      (en_q[GLB_BIT]),
      .pri_src  (pri_q[NSRC-1:0]),
      .allow_hi (allow_hi),
      .allow_lo (allow_lo),
      .valid    (win_valid),
      .win_hi   (win_hi),
      .idx      (win_idx),
      .grant    (grant),
      .vec      (irq_vec)
   );

   vic2_svc_stack #(.DEPTH(SVC_DEPTH)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_hi  (win_hi),
      .pop      (irq_ret),
      .depth    (svc_depth),
      .top_hi   (top_hi),
      .allow_hi (allow_hi),
      .allow_lo (allow_lo)
   );

   assign irq_req = win_valid;
   assign irq_hi  = win_hi;

   // R1: global enable off silences every source
   p_glb_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[GLB_BIT] |-> !irq_req);
   // R2: the presented source is enabled and pending
   p_src_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> |(grant & en_q[NSRC-1:0] & pend));
   // R4: over a low routine only a high request is shown
   p_preempt_hi_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_depth != '0 && !top_hi) |-> (!irq_req || irq_hi));
   // R5: a high routine blocks everything
   p_hi_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_depth != DW'(0) && top_hi) |-> !irq_req);
   // R8: accepting timer 0 without a new overflow clears its flag
   p_tmr0_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && grant[SRC_T0] && !tmr0_ovf) |=> !flag_q[1]);
endmodule

// File: tb/vic2_ctrl_tb_top.sv
module vic2_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0, cfg_wr_pri = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] en_rd, pri_rd;
   logic [1:0] ext_n = 2'b11, ext_type = 2'b00;
   logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, ser_flag = 1'b0, tm2_flag = 1'b0;
   logic       irq_ack = 1'b0, irq_ret = 1'b0;
   logic       irq_req, irq_hi;
   logic [7:0] irq_vec;
   logic [3:0] flag_q;
   logic [1:0] svc_depth;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic       req;
      logic [7:0] vec;
      logic [3:0] flg;
      logic [1:0] dep;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   vic2_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_pri(cfg_wr_pri),
      .cfg_wdata(cfg_wdata), .en_rd(en_rd), .pri_rd(pri_rd), .ext_n(ext_n),
      .ext_type(ext_type), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
      .ser_flag(ser_flag), .tm2_flag(tm2_flag), .irq_ack(irq_ack),
      .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec), .irq_hi(irq_hi),
      .flag_q(flag_q), .svc_depth(svc_depth)
   );

   // monitor: compare one expected item per falling edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (irq_req !== e.req || irq_vec !== e.vec || flag_q !== e.flg || svc_depth !== e.dep) begin
            errors++;
            $display("FAIL %s: got req=%b vec=%h flg=%b dep=%0d exp req=%b vec=%h flg=%b dep=%0d",
                     e.tag, irq_req, irq_vec, flag_q, svc_depth, e.req, e.vec, e.flg, e.dep);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic expect_st(input logic r, input logic [7:0] v, input logic [3:0] f,
                            input logic [1:0] d, input string tag);
      exp_t e;
      e.req = r; e.vec = v; e.flg = f; e.dep = d; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk); #1;
   endtask

   task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h exp %h", tag, act, exp);
      end
   endtask

   task automatic wr_en(input logic [7:0] d);
      cfg_wdata = d; cfg_wr_en = 1'b1; tick(); cfg_wr_en = 1'b0;
   endtask
   task automatic wr_pri(input logic [7:0] d);
      cfg_wdata = d; cfg_wr_pri = 1'b1; tick(); cfg_wr_pri = 1'b0;
   endtask
   task automatic do_ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask
   task automatic do_ret();
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
   endtask
   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      tick();
      // R11 reset state
      expect_st(1'b0, 8'h00, 4'b0000, 2'd0, "R11 reset outputs");
      chk8(en_rd, 8'h00, "R11 enable after reset");
      chk8(pri_rd, 8'h00, "R11 priority after reset");
      wr_en(8'hFF);
      chk8(en_rd, 8'hBF, "R11 enable bit 6 reads 0");
      wr_pri(8'hFF);
      chk8(pri_rd, 8'h3F, "R11 priority bits 7..6 read 0");
      wr_pri(8'h00);

      // R1 global enable off
      wr_en(8'h3F);
      tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
      expect_st(1'b0, 8'h00, 4'b0010, 2'd0, "R1 global off blocks timer0");
      wr_en(8'hBF);
      expect_st(1'b1, 8'h0B, 4'b0010, 2'd0, "R1 global on presents timer0");

      // R2 per-source enable
      wr_en(8'hBD);
      expect_st(1'b0, 8'h00, 4'b0010, 2'd0, "R2 timer0 disabled");
      wr_en(8'hBF);

      // R3 ordering, R8 clear, R4 same-level wait
      tmr1_ovf = 1'b1; ser_flag = 1'b1; tick(); tmr1_ovf = 1'b0;
      expect_st(1'b1, 8'h0B, 4'b1010, 2'd0, "R3 timer0 beats timer1 and serial");
      do_ack();
      expect_st(1'b0, 8'h00, 4'b1000, 2'd1, "R8 timer0 flag cleared, R4 low waits");
      do_ret();
      expect_st(1'b1, 8'h1B, 4'b1000, 2'd0, "R10 pop, R3 timer1 next");
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd1, "R8 timer1 flag cleared");
      do_ret();
      expect_st(1'b1, 8'h23, 4'b0000, 2'd0, "R3 serial vector");

      // R9 serial not cleared by acknowledge
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd1, "R9 serial in service");
      do_ret();
      expect_st(1'b1, 8'h23, 4'b0000, 2'd0, "R9 serial requests again");
      ser_flag = 1'b0;
      expect_st(1'b0, 8'h00, 4'b0000, 2'd0, "R9 serial dropped by source");

      // R4 preemption, R5 high blocks all
      tm2_flag = 1'b1;
      expect_st(1'b1, 8'h2B, 4'b0000, 2'd0, "R3 timer2 vector");
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd1, "R4 low in service");
      wr_pri(8'h02);
      tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
      expect_st(1'b1, 8'h0B, 4'b0010, 2'd1, "R4 high timer0 preempts");
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd2, "R5 high in service");
      wr_pri(8'h0A);
      tmr1_ovf = 1'b1; tick(); tmr1_ovf = 1'b0;
      expect_st(1'b0, 8'h00, 4'b1000, 2'd2, "R5 high timer1 blocked by high");
      do_ret();
      expect_st(1'b1, 8'h1B, 4'b1000, 2'd1, "R4 timer1 preempts after pop");
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd2, "R10 second high pushed");
      do_ret();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd1, "R4 timer2 still waits at low");
      do_ret();
      expect_st(1'b1, 8'h2B, 4'b0000, 2'd0, "R10 stack empty, timer2 again");
      tm2_flag = 1'b0;
      wr_pri(8'h00);

      // R6 edge-mode ext0
      ext_type = 2'b01;
      ext_n[0] = 1'b0;
      wait_n(4);
      expect_st(1'b1, 8'h03, 4'b0001, 2'd0, "R6 falling edge latches ext0");
      ext_n[0] = 1'b1;
      wait_n(4);
      expect_st(1'b1, 8'h03, 4'b0001, 2'd0, "R6 flag holds after pin high");
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd1, "R8 ext0 edge flag cleared");
      do_ret();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd0, "R10 return to idle");

      // R7 level-mode ext1
      ext_n[1] = 1'b0;
      wait_n(4);
      expect_st(1'b1, 8'h13, 4'b0000, 2'd0, "R7 low level requests ext1");
      ext_n[1] = 1'b1;
      wait_n(4);
      expect_st(1'b0, 8'h00, 4'b0000, 2'd0, "R7 request gone with pin high");

      // R12 stray pulses
      do_ack();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd0, "R12 ack without request");
      do_ret();
      expect_st(1'b0, 8'h00, 4'b0000, 2'd0, "R12 return with empty stack");

      wait_n(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule